// File: doc/BRIEF.md
# Peripheral adapter interrupt flag and enable unit

This block holds the interrupt state of a peripheral adapter that exposes sixteen byte-wide registers. It keeps a 7-bit flag vector and a 7-bit enable mask. It collects one-cycle set pulses from the first timer, the second timer and the shift register, and it drives a single level interrupt line towards the processor. Register accesses arrive on a plain strobe bus. Bits [12:9] of the address pick the register. Every other address bit is ignored.

Software clears flags in two ways. It can write the flag register directly, with a 1 in each bit to be cleared. It can also clear a flag by touching the data register of the unit that raised it: reading the low byte of either timer counter, reading the shift register, or writing a high byte of the first timer. The enable register is written with a set/clear convention chosen by bit 7.

Reading the flag register returns a summary bit in bit 7, which is 1 when some flag is both set and enabled. Reading the enable register always returns bit 7 as 1. A hardware set pulse that lands in the same cycle as a clearing access wins, so no event is lost.

Top module: `via_irq_unit`

## Requirements
- R1: After reset all flags and all enables are 0, the interrupt line is low, the flag register reads 0x00 and the enable register reads 0x80.
- R2: Only address bits [12:9] select the register; changing any other address bit does not change the result of an access.
- R3: A pulse on the first-timer, second-timer or shift-register event input sets flag bit 6, 5 or 2 respectively, and the flag stays set until a clearing access.
- R4: Writing register 13 (flags) clears every flag bit [6:0] that is 1 in the written byte and leaves the others unchanged.
- R5: Writing register 14 (enables) with bit 7 = 1 ORs bits [6:0] into the enable mask. With bit 7 = 0, it clears every enable bit that is 1 in bits [6:0].
- R6: Reading register 13 returns the flags in bits [6:0], with bit 7 = 1 exactly when (flags AND enables) is nonzero.
- R7: Reading register 14 returns the enable mask in bits [6:0], with bit 7 always 1.
- R8: The interrupt line is high exactly when flag bit 2 or flag bit 6 is both set and enabled. Flag bit 5 never drives the line.
- R9: Reading register 4 clears flag bit 6, reading register 8 clears flag bit 5, and reading register 10 clears flag bit 2.
- R10: Writing register 5 or register 7 clears flag bit 6. Writing register 4 or register 6 leaves it set.
- R11: If a set pulse and a clearing access for the same flag occur in the same cycle, the flag ends up set.
- R12: Reads of registers other than 13 and 14 return 0x00. Writes to registers other than 5, 7, 13 and 14 change neither flags nor enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address; bits [12:9] select the register |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| ev_t1_set | input | 1 | First-timer event pulse |
| ev_t2_set | input | 1 | Second-timer event pulse |
| ev_sr_set | input | 1 | Shift-register event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each event source is raised on its own and then in combination with the others, under several enable masks. This separates the flag bits from one another and shows that only bits 2 and 6 reach the interrupt line, while bit 5 still reaches the read summary bit. Every clearing path is tried once: the direct flag write, the three reads with side effects, and the two high-byte writes. Each path is paired with the neighbouring register that must not clear, so a swapped or wrong index decode shows up. Set pulses are also issued in the very cycle of a clearing access, and accesses are repeated with junk in the unused address bits, to check that the set wins and that the index is taken only from bits [12:9].

// File: rtl/via_irq_pkg.sv
package via_irq_pkg;

  localparam int FLAG_W   = 7;
  localparam int IDX_W    = 4;

  localparam int BIT_SR   = 2;
  localparam int BIT_T2   = 5;
  localparam int BIT_T1   = 6;

  localparam logic [IDX_W-1:0] IDX_T1_LO  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_T1_HI  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_T1_LHI = 4'd7;
  localparam logic [IDX_W-1:0] IDX_T2_LO  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SHIFT  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_FLAGS  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd14;

  localparam logic [FLAG_W-1:0] IRQ_LINE_MASK =
    FLAG_W'((1 << BIT_SR) | (1 << BIT_T1));

  // Enable-mask update under the set/clear convention carried in bit 7.
  function automatic logic [FLAG_W-1:0] fn_enable_next(
    input logic [FLAG_W-1:0] cur,
    input logic [7:0]        wd
  );
    if (wd[7]) return cur | wd[FLAG_W-1:0];
    else       return cur & ~wd[FLAG_W-1:0];
  endfunction

  // Any flag that is both raised and enabled.
  function automatic logic fn_pending(
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] en
  );
    return |(flags & en);
  endfunction

  // Per-bit flag update: the set pulse wins over the clear request.
  function automatic logic fn_flag_next(
    input logic cur,
    input logic set_req,
    input logic clr_req
  );
    return set_req | (cur & ~clr_req);
  endfunction

  // Read-data selection for the two registers owned by this unit.
  function automatic logic [7:0] fn_read_mux(
    input logic [IDX_W-1:0]  idx,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] en
  );
    logic [7:0] r;
    r = 8'h00;
    if (idx == IDX_FLAGS)  r = {fn_pending(flags, en), flags};
    if (idx == IDX_ENABLE) r = {1'b1, en};
    return r;
  endfunction

endpackage

// File: rtl/via_reg_decode.sv
module via_reg_decode
  import via_irq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_LSB = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_t1_lo,
  output logic              rd_t2_lo,
  output logic              rd_shift,
  output logic              wr_t1_high,
  output logic              wr_flags,
  output logic              wr_enable
);

  // The full address is kept only for the index slice below.
  logic [ADDR_W-1:0] unused_addr;
  assign unused_addr = addr;

  assign idx = addr[IDX_LSB +: IDX_W];

  // Access events that carry side effects, brought out by name.
  assign rd_t1_lo   = rd && (idx == IDX_T1_LO);
  assign rd_t2_lo   = rd && (idx == IDX_T2_LO);
  assign rd_shift   = rd && (idx == IDX_SHIFT);
  assign wr_t1_high = wr && ((idx == IDX_T1_HI) || (idx == IDX_T1_LHI));
  assign wr_flags   = wr && (idx == IDX_FLAGS);
  assign wr_enable  = wr && (idx == IDX_ENABLE);

endmodule

// File: rtl/via_flag_bank.sv
module via_flag_bank
  import via_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_vec,
  input  logic [FLAG_W-1:0] clr_vec,
  output logic [FLAG_W-1:0] flags_q
);

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= fn_flag_next(flags_q[i], set_vec[i], clr_vec[i]);
    end

    // R11: a set pulse is never lost to a simultaneous clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_q[i]);

    // R3: a raised flag holds until something clears it
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);

    // R4: a clear request without a set drops the flag
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
  end

endmodule

// File: rtl/via_enable_mask.sv
module via_enable_mask
  import via_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable,
  input  logic [7:0]        wdata,
  output logic [FLAG_W-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_enable) en_q <= fn_enable_next(en_q, wdata);
  end

  // R5: set form leaves every selected bit enabled
  a_r5_set_form: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && wdata[7]) |=>
      ((en_q & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0])));

  // R5: clear form leaves every selected bit disabled
  a_r5_clear_form: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_enable && !wdata[7]) |=> ((en_q & $past(wdata[FLAG_W-1:0])) == '0));

  // R12: no enable write, no change
  a_r12_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(en_q));

endmodule

// File: rtl/via_irq_unit.sv
module via_irq_unit
  import via_irq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IDX_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_t1_set,
  input  logic              ev_t2_set,
  input  logic              ev_sr_set,
  output logic              irq_o
);

  logic [IDX_W-1:0]  idx;
  logic              rd_t1_lo, rd_t2_lo, rd_shift;
  logic              wr_t1_high, wr_flags, wr_enable;
  logic [FLAG_W-1:0] set_vec, side_clr, clr_vec;
  logic [FLAG_W-1:0] flags_q, en_q;
  logic              pending;

  via_reg_decode #(
    .ADDR_W  (ADDR_W),
    .IDX_LSB (IDX_LSB)
  ) u_decode (
    .addr       (bus_addr),
    .rd         (bus_rd),
    .wr         (bus_wr),
    .idx        (idx),
    .rd_t1_lo   (rd_t1_lo),
    .rd_t2_lo   (rd_t2_lo),
    .rd_shift   (rd_shift),
    .wr_t1_high (wr_t1_high),
    .wr_flags   (wr_flags),
    .wr_enable  (wr_enable)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_T1]  = ev_t1_set;
    set_vec[BIT_T2]  = ev_t2_set;
    set_vec[BIT_SR]  = ev_sr_set;

    side_clr         = '0;
    side_clr[BIT_T1] = rd_t1_lo | wr_t1_high;
    side_clr[BIT_T2] = rd_t2_lo;
    side_clr[BIT_SR] = rd_shift;

    clr_vec = side_clr | (wr_flags ? bus_wdata[FLAG_W-1:0] : '0);
  end

  via_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  via_enable_mask u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_enable (wr_enable),
    .wdata     (bus_wdata),
    .en_q      (en_q)
  );

  assign pending   = fn_pending(flags_q, en_q);
  assign bus_rdata = fn_read_mux(idx, flags_q, en_q);
  assign irq_o     = |(flags_q & en_q & IRQ_LINE_MASK);

  // R7: enable register reads with bit 7 high
  a_r7_enable_read_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_ENABLE) |-> bus_rdata[7]);

  // R6: summary bit is low when nothing enabled is pending
  a_r6_summary_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_FLAGS && !pending) |-> !bus_rdata[7]);

  // R8: without a shift or first-timer flag the line stays low
  a_r8_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[BIT_SR] && !flags_q[BIT_T1]) |-> !irq_o);

  // R8: an enabled first-timer flag raises the line
  a_r8_line_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[BIT_T1] && en_q[BIT_T1]) |-> irq_o);

  // R9: reading the first-timer low byte clears its flag
  a_r9_t1_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_T1_LO && !ev_t1_set) |=> !flags_q[BIT_T1]);

  // R10: writing a first-timer high byte clears its flag
  a_r10_t1_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (idx == IDX_T1_HI || idx == IDX_T1_LHI) && !ev_t1_set)
      |=> !flags_q[BIT_T1]);

  // R12: other registers read as zero
  a_r12_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx != IDX_FLAGS && idx != IDX_ENABLE) |-> (bus_rdata == 8'h00));

endmodule

// File: tb/test_via_irq_unit.sv
module test_via_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ev_t1_set = 1'b0, ev_t2_set = 1'b0, ev_sr_set = 1'b0;
  logic        irq_o;

  always #10 clk = ~clk;

  via_irq_unit i_via_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_t1_set(ev_t1_set), .ev_t2_set(ev_t2_set), .ev_sr_set(ev_sr_set),
    .irq_o(irq_o)
  );

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [6:0] m_flag = '0, m_en = '0;

  task automatic compare(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] idx);
    if (idx == 4'd13) return {|(m_flag & m_en), m_flag};
    if (idx == 4'd14) return {1'b1, m_en};
    return 8'h00;
  endfunction

  // Monitor: every read cycle pops one expected item.
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      if (sb_q.size() == 0) compare("scoreboard underflow", bus_rdata, 8'hxx);
      else begin
        item_t it;
        it = sb_q.pop_front();
        compare(it.tag, bus_rdata, it.exp);
      end
    end
  end

  // ev = {t1, t2, sr}
  task automatic access(input bit r, input bit w, input logic [3:0] idx,
                        input logic [7:0] wd, input logic [2:0] ev,
                        input logic [15:0] noise, input string tag);
    logic [6:0] c;
    bus_addr  = (noise & ~16'h1E00) | (16'(idx) << 9);
    bus_rd    = r;
    bus_wr    = w;
    bus_wdata = wd;
    ev_t1_set = ev[2];
    ev_t2_set = ev[1];
    ev_sr_set = ev[0];
    if (r) begin
      item_t it;
      it.exp = model_read(idx);
      it.tag = tag;
      sb_q.push_back(it);
    end
    @(posedge clk); #1;
    c = '0;
    if (r && idx == 4'd4)  c[6] = 1'b1;
    if (r && idx == 4'd8)  c[5] = 1'b1;
    if (r && idx == 4'd10) c[2] = 1'b1;
    if (w && (idx == 4'd5 || idx == 4'd7)) c[6] = 1'b1;
    if (w && idx == 4'd13) c = c | wd[6:0];
    if (w && idx == 4'd14) m_en = wd[7] ? (m_en | wd[6:0]) : (m_en & ~wd[6:0]);
    m_flag = (m_flag & ~c) | {ev[2], ev[1], 2'b00, ev[0], 2'b00};
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    ev_t1_set = 1'b0; ev_t2_set = 1'b0; ev_sr_set = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input string tag);
    access(1'b1, 1'b0, idx, 8'h00, 3'b000, 16'h0000, tag);
  endtask
  task automatic wr(input logic [3:0] idx, input logic [7:0] d, input string tag);
    access(1'b0, 1'b1, idx, d, 3'b000, 16'h0000, tag);
  endtask
  task automatic pulse(input logic [2:0] ev, input string tag);
    access(1'b0, 1'b0, 4'd0, 8'h00, ev, 16'h0000, tag);
  endtask
  task automatic chk_irq(input string tag);
    compare(tag, {7'b0, irq_o}, {7'b0, |(m_flag & m_en & 7'h44)});
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk_irq("R1 irq after reset");
    rd(4'd13, "R1 flags after reset");
    rd(4'd14, "R1/R7 enables after reset");

    // R3 first timer sets bit 6; not enabled yet
    pulse(3'b100, "t1");
    rd(4'd13, "R3/R6 t1 flag raised, summary low");
    chk_irq("R8 t1 not enabled");
    wr(4'd14, 8'hC0, "enable t1");
    rd(4'd14, "R5/R7 enable set form");
    rd(4'd13, "R6 summary high");
    chk_irq("R8 t1 enabled drives line");

    // Second timer: summary yes, line no
    pulse(3'b010, "t2");
    wr(4'd14, 8'hA0, "enable t2");
    rd(4'd13, "R3 t1 and t2 flags");
    wr(4'd13, 8'h40, "R4 clear t1 by flag write");
    rd(4'd13, "R4/R6 t2 left, summary from t2");
    chk_irq("R8 t2 alone keeps line low");
    wr(4'd14, 8'h20, "R5 clear form");
    rd(4'd14, "R5 enable bit 5 cleared");

    // Shift register flag
    pulse(3'b001, "sr");
    wr(4'd14, 8'h84, "enable sr");
    chk_irq("R8 sr drives line");
    rd(4'd10, "R9 read shift register");
    chk_irq("R9 sr cleared by shift read");
    rd(4'd13, "R9 flags after shift read");
    rd(4'd8, "R9/R12 read t2 low");
    rd(4'd13, "R9 t2 cleared by t2 low read");

    // First-timer read side effects
    pulse(3'b100, "t1 again");
    rd(4'd5, "R12 t1 high read returns zero");
    rd(4'd13, "R9 t1 high read does not clear");
    rd(4'd4, "R9 read t1 low");
    rd(4'd13, "R9 t1 cleared by low read");

    // First-timer write side effects
    pulse(3'b100, "t1 for writes");
    wr(4'd4, 8'h55, "write t1 latch low");
    wr(4'd6, 8'h55, "write t1 latch low alt");
    rd(4'd13, "R10 low writes keep t1");
    wr(4'd5, 8'h12, "write t1 high");
    rd(4'd13, "R10 write 5 clears t1");
    pulse(3'b100, "t1 for reg 7");
    wr(4'd7, 8'h12, "write t1 latch high");
    rd(4'd13, "R10 write 7 clears t1");
    chk_irq("R10 line low after clear");

    // R11 set wins over clear in the same cycle
    access(1'b1, 1'b0, 4'd4, 8'h00, 3'b100, 16'h0000, "R11 t1 read with set");
    rd(4'd13, "R11 t1 survives read clear");
    access(1'b0, 1'b1, 4'd13, 8'h7F, 3'b001, 16'h0000, "R11 sr set with flag write");
    rd(4'd13, "R11 sr survives flag write");
    chk_irq("R11 line high");

    // R12 writes elsewhere change nothing
    wr(4'd0, 8'hFF, "write reg 0");
    wr(4'd11, 8'hFF, "write reg 11");
    wr(4'd15, 8'hFF, "write reg 15");
    rd(4'd13, "R12 flags unchanged");
    rd(4'd14, "R12 enables unchanged");

    // R2 unused address bits
    access(1'b1, 1'b0, 4'd13, 8'h00, 3'b000, 16'hE1FF, "R2 flags read with noise");
    access(1'b0, 1'b1, 4'd14, 8'h80 | 8'h20, 3'b000, 16'hC0AA, "R2 enable write with noise");
    access(1'b1, 1'b0, 4'd14, 8'h00, 3'b000, 16'hFFFF, "R2 enable read with noise");
    access(1'b1, 1'b0, 4'd10, 8'h00, 3'b000, 16'h81F3, "R2 shift read with noise");
    rd(4'd13, "R2 side effect decoded through noise");
    chk_irq("R2 line after noisy clear");

    repeat (2) @(posedge clk);
    #1;
    compare("scoreboard drained", 8'(sb_q.size()), 8'h00);
    summary();
  end

endmodule